// File: doc/BRIEF.md
# One-Dimensional Cellular Automaton Engine

The engine evolves a binary cellular automaton whose cells each look only at themselves and their two direct neighbours. It paints every generation as one row of a single-bit frame buffer. The default buffer is 320 columns by 240 rows. The engine drives only the buffer's write side, one cell per clock, working left to right and top to bottom. A display controller can read the buffer independently.

Two inputs set up a run, and both are sampled on the first clock after reset is released. One is an 8-bit rule number. The other is a select that chooses how the first row is seeded: either a lone live cell in the middle, or a row of pseudo-random bits. Once the bottom row is written, the engine halts. A continue pulse then starts a new screen. That screen begins with the previous bottom row as its top row and evolves from it for exactly one more frame, after which the engine halts again.

Top module: `ca_engine`

## Requirements
- R1: While `rst_ni` is low, `wr_en_o` and `halted_o` are 0. `rule_i` and `seed_rand_i` are sampled on the first rising clock after reset is released, and later changes to them have no effect until the next reset.
- R2: A cell in generation g+1 takes the value `rule[{left, self, right}]` of generation g. The left neighbour is column c-1 and forms the most significant bit of the index.
- R3: The neighbour of column 0 on the left, and the neighbour of column W-1 on the right, read as 0.
- R4: With `seed_rand_i`=0, row 0 holds a 1 only in column W/2 (integer division). Every other cell of row 0 is 0.
- R5: With `seed_rand_i`=1, column c of row 0 equals bit 0 of a 16-bit shift register after c steps. The register starts from 16'hACE1 at reset. Each step does `s = {s[0]^s[2]^s[3]^s[5], s[15:1]}`.
- R6: Writes happen on consecutive cycles with no gaps. The order is row-major, with columns 0..W-1 inside rows 0..H-1, for exactly W*H writes per screen.
- R7: On the cycle after the write of row H-1, column W-1, `halted_o` is 1. It stays 1, with no writes, until a continue pulse arrives.
- R8: When `cont_i` is high while halted, the engine writes the previous bottom row to row 0. It then writes H-1 further generations and halts again.
- R9: `cont_i` pulses that arrive while a screen is being written are ignored. They neither extend the run nor start another screen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rule_i | input | 8 | Rule number, sampled after reset |
| seed_rand_i | input | 1 | Seed select: 0 centre cell, 1 pseudo-random |
| cont_i | input | 1 | Continue request |
| wr_row_o | output | $clog2(H) | Frame buffer row address |
| wr_col_o | output | $clog2(W) | Frame buffer column address |
| wr_data_o | output | 1 | Cell value to store |
| wr_en_o | output | 1 | Write strobe |
| halted_o | output | 1 | Screen complete, waiting for continue |

## Verification
The bench rebuilds every screen from the rule and the seed definition, and compares it row by row. It uses rules whose outputs differ at the edge patterns, so an engine that wrapped its edges or reversed its neighbour order would corrupt the outer columns. It changes the rule inputs after reset; a design that kept sampling them would produce the wrong rows. It also checks that the continued screen starts with the old bottom row, not a fresh seed. Finally, it pulses continue in the middle of a screen: a design that remembered that pulse would keep writing after the halt.

// File: rtl/ca_pkg.sv
package ca_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_SEED,
    ST_COPY,
    ST_GEN,
    ST_HALT
  } ca_state_e;

  localparam logic [15:0] LFSR_INIT = 16'hACE1;
endpackage

// File: rtl/ca_lfsr.sv
module ca_lfsr #(
  parameter logic [15:0] INIT = 16'hACE1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic bit_o
);
  logic [15:0] lfsr_q;
  logic        fb;

  assign fb    = lfsr_q[0] ^ lfsr_q[2] ^ lfsr_q[3] ^ lfsr_q[5];
  assign bit_o = lfsr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= INIT;
    else if (step_i) lfsr_q <= {fb, lfsr_q[15:1]};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != 16'h0000); // R5
endmodule

// File: rtl/ca_next_row.sv
module ca_next_row #(
  parameter int W = 320
) (
  input  logic [W-1:0] cur_i,
  input  logic [7:0]   rule_i,
  output logic [W-1:0] nxt_o
);
  for (genvar c = 0; c < W; c++) begin : g_cell
    logic lft, rgt;
    if (c == 0) begin : g_ledge
      assign lft = 1'b0;
    end else begin : g_lin
      assign lft = cur_i[c-1];
    end
    if (c == W-1) begin : g_redge
      assign rgt = 1'b0;
    end else begin : g_rin
      assign rgt = cur_i[c+1];
    end
    assign nxt_o[c] = rule_i[{lft, cur_i[c], rgt}];
  end
endmodule

// File: rtl/ca_engine.sv
module ca_engine
  import ca_pkg::*;
#(
  parameter int W     = 320,
  parameter int H     = 240,
  parameter int COL_W = $clog2(W),
  parameter int ROW_W = $clog2(H)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       rule_i,
  input  logic             seed_rand_i,
  input  logic             cont_i,
  output logic [ROW_W-1:0] wr_row_o,
  output logic [COL_W-1:0] wr_col_o,
  output logic             wr_data_o,
  output logic             wr_en_o,
  output logic             halted_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(W-1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(H-1);
  localparam logic [COL_W-1:0] COL_MID  = COL_W'(W/2);

  ca_state_e        state_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [W-1:0]     cur_row_q;
  logic [W-1:0]     nxt_row;
  logic [7:0]       rule_q;
  logic             rand_q;
  logic             rnd_bit;
  logic             seed_bit;
  logic             last_col, last_row;

  ca_lfsr #(.INIT(LFSR_INIT)) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (state_q == ST_SEED && rand_q),
    .bit_o  (rnd_bit)
  );

  ca_next_row #(.W(W)) i_next_row (
    .cur_i  (cur_row_q),
    .rule_i (rule_q),
    .nxt_o  (nxt_row)
  );

  assign last_col = (col_q == COL_LAST);
  assign last_row = (row_q == ROW_LAST);
  assign seed_bit = rand_q ? rnd_bit : (col_q == COL_MID);

  always_comb begin
    unique case (state_q)
      ST_SEED: wr_data_o = seed_bit;
      ST_COPY: wr_data_o = cur_row_q[col_q];
      ST_GEN:  wr_data_o = nxt_row[col_q];
      default: wr_data_o = 1'b0;
    endcase
  end

  assign wr_en_o  = (state_q == ST_SEED) || (state_q == ST_COPY) || (state_q == ST_GEN);
  assign wr_row_o = row_q;
  assign wr_col_o = col_q;
  assign halted_o = (state_q == ST_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_LOAD;
      row_q     <= '0;
      col_q     <= '0;
      cur_row_q <= '0;
      rule_q    <= '0;
      rand_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_LOAD: begin
          rule_q  <= rule_i;
          rand_q  <= seed_rand_i;
          row_q   <= '0;
          col_q   <= '0;
          state_q <= ST_SEED;
        end
        ST_SEED, ST_COPY: begin
          if (state_q == ST_SEED) cur_row_q[col_q] <= seed_bit;
          if (last_col) begin
            col_q   <= '0;
            row_q   <= ROW_W'(1);
            state_q <= ST_GEN;
          end else begin
            col_q <= col_q + COL_W'(1);
          end
        end
        ST_GEN: begin
          if (last_col) begin
            cur_row_q <= nxt_row;
            col_q     <= '0;
            if (last_row) state_q <= ST_HALT;
            else          row_q   <= row_q + ROW_W'(1);
          end else begin
            col_q <= col_q + COL_W'(1);
          end
        end
        ST_HALT: begin
          // bottom row already sits in cur_row_q and becomes the new top
          if (cont_i) begin
            row_q   <= '0;
            col_q   <= '0;
            state_q <= ST_COPY;
          end
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !last_col) |=> (wr_en_o && wr_col_o == $past(wr_col_o) + COL_W'(1)
                                && $stable(wr_row_o))); // R6
  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && last_col && !last_row) |=> (wr_en_o && wr_col_o == '0
                                && wr_row_o == $past(wr_row_o) + ROW_W'(1))); // R6
  AST_HALT_AT_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && last_col && last_row) |=> halted_o); // R7
  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !cont_i) |=> (halted_o && !wr_en_o)); // R7
  AST_RESUME_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halted_o) |-> (wr_en_o && wr_row_o == '0 && wr_col_o == '0)); // R8
  AST_CONT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !(last_col && last_row)) |=> !halted_o); // R9
endmodule

// File: tb/test_ca_engine.sv
module test_ca_engine;
  localparam int W = 16;
  localparam int H = 8;
  localparam int CW = $clog2(W);
  localparam int RW = $clog2(H);

  // {seed_rand, rule}
  localparam logic [8:0] VEC [7] = '{
    {1'b0, 8'd30}, {1'b0, 8'd90}, {1'b1, 8'd110}, {1'b1, 8'd184},
    {1'b0, 8'd1},  {1'b1, 8'd254}, {1'b1, 8'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    rule = 8'd0;
  logic          seed_rand = 1'b0;
  logic          cont = 1'b0;
  logic [RW-1:0] wr_row;
  logic [CW-1:0] wr_col;
  logic          wr_data, wr_en, halted;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int wcnt = 0;
  int exp_pos = 0;
  int order_bad = 0;
  int gaps = 0;
  bit started = 0;

  logic [W-1:0] got [H];
  logic [W-1:0] expf [H];

  always #2.5 clk = ~clk;

  ca_engine #(.W(W), .H(H)) i_ca_engine (
    .clk_i(clk), .rst_ni(rst_n), .rule_i(rule), .seed_rand_i(seed_rand), .cont_i(cont),
    .wr_row_o(wr_row), .wr_col_o(wr_col), .wr_data_o(wr_data), .wr_en_o(wr_en),
    .halted_o(halted)
  );

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      got[wr_row][wr_col] = wr_data;
      if (int'(wr_row) * W + int'(wr_col) != exp_pos) order_bad++;
      exp_pos++;
      wcnt++;
      started = 1;
    end else if (rst_n && started && !halted) begin
      gaps++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] step_row(input logic [W-1:0] r, input logic [7:0] ru);
    logic [W-1:0] n;
    for (int c = 0; c < W; c++) begin
      logic l, m, x;
      l = (c == 0) ? 1'b0 : r[c-1];
      x = (c == W-1) ? 1'b0 : r[c+1];
      m = r[c];
      n[c] = ru[{l, m, x}];
    end
    return n;
  endfunction

  function automatic logic [W-1:0] seed_row(input bit rnd);
    logic [W-1:0] s = '0;
    logic [15:0]  l = 16'hACE1;
    for (int c = 0; c < W; c++) begin
      if (rnd) begin
        s[c] = l[0];
        l = {l[0] ^ l[2] ^ l[3] ^ l[5], l[15:1]};
      end else begin
        s[c] = (c == W/2);
      end
    end
    return s;
  endfunction

  task automatic build(input logic [W-1:0] top, input logic [7:0] ru);
    expf[0] = top;
    for (int r = 1; r < H; r++) expf[r] = step_row(expf[r-1], ru);
  endtask

  task automatic clear_capture();
    for (int r = 0; r < H; r++) got[r] = 'x;
    wcnt = 0; exp_pos = 0; order_bad = 0; gaps = 0; started = 0;
  endtask

  task automatic do_reset(input logic [7:0] ru, input bit rnd);
    @(negedge clk);
    rst_n = 1'b0; rule = ru; seed_rand = rnd; cont = 1'b0;
    clear_capture();
    @(negedge clk);
    @(negedge clk);
    chk(!wr_en && !halted, "R1 reset outputs", {wr_en, halted}, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt();
    for (int n = 0; n < 4000 && !halted; n++) @(negedge clk);
  endtask

  task automatic cmp_frame(input string req);
    for (int r = 0; r < H; r++) chk(got[r] === expf[r], req, got[r], expf[r]);
  endtask

  task automatic cmp_order();
    chk(wcnt == W*H, "R6 write count", wcnt, W*H);
    chk(order_bad == 0 && gaps == 0, "R6 order/gaps", order_bad + gaps, 0);
  endtask

  initial begin
    logic [W-1:0] bottom;
    int quiet;

    // table walk: R2 R3 R4 R5
    foreach (VEC[i]) begin
      do_reset(VEC[i][7:0], VEC[i][8]);
      wait_halt();
      chk(halted, "R7 halts after screen", halted, 1);
      build(seed_row(VEC[i][8]), VEC[i][7:0]);
      chk(got[0] === expf[0], VEC[i][8] ? "R5 random seed" : "R4 centre seed", got[0], expf[0]);
      cmp_frame("R2 R3 generations");
      cmp_order();
    end

    // R1: inputs changed after reset have no effect
    do_reset(8'd30, 1'b0);
    @(negedge clk);
    @(negedge clk);
    rule = 8'd90; seed_rand = 1'b1;
    wait_halt();
    build(seed_row(1'b0), 8'd30);
    cmp_frame("R1 late rule change ignored");

    // R7 hold, R8 continue, R9 ignore mid-screen pulse
    do_reset(8'd110, 1'b1);
    wait_halt();
    bottom = got[H-1];
    quiet = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (wr_en || !halted) quiet++;
    end
    chk(quiet == 0, "R7 stays halted", quiet, 0);

    clear_capture();
    cont = 1'b1;
    @(negedge clk);
    cont = 1'b0;
    for (int n = 0; n < 30; n++) @(negedge clk);
    cont = 1'b1;               // mid-screen pulse, must be dropped
    @(negedge clk);
    cont = 1'b0;
    wait_halt();
    build(bottom, 8'd110);
    chk(got[0] === bottom, "R8 top row is old bottom", got[0], bottom);
    cmp_frame("R8 continued screen");
    cmp_order();

    quiet = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (wr_en || !halted) quiet++;
    end
    chk(quiet == 0 && wcnt == W*H, "R9 mid-screen continue ignored", quiet + wcnt, W*H);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule